// File: doc/BRIEF.md
# Bus Transceiver Mode Qualifier

This block chooses the signalling mode of a bus transceiver (single-ended or low-voltage differential) from a mode-sense line whose voltage external comparators have already classified into a 2-bit code. It also decides when the line drivers may leave high impedance. After reset the drivers stay off until two things have happened in order. First, the logic-ready input has been held for a full power-up window. Then a defined sense code has stayed the same for a full settling window. Only after both does the block enable the drivers and publish the mode.

Once running, the block does not follow the sense line directly. A different mode has to be sensed without a break for a full switch window before it is committed. An undefined reading, or a return to the current mode, cancels a pending switch. All windows are counted in milliseconds: a prescaler divides the clock by `TICKS_PER_MS` and feeds a millisecond counter. The lengths are `PWRUP_MS`, `SETTLE_MS` and `SWITCH_MS`. `rst_i` is a synchronous reset and returns the block to the powered-up, drivers-off state.

Top module: `xcvr_mode_qual`

## Requirements
- R1: While `rst_i` is high and on the first cycle after it, `drv_en_o` = 0, `mode_valid_o` = 0 and `mode_o` = 0 (single-ended).
- R2: `drv_en_o` stays 0 until `logic_ready_i` has been sampled high on PWRUP_MS*TICKS_PER_MS consecutive rising edges. A low sample restarts that count from zero.
- R3: Sense codes are 2'b00 = single-ended and 2'b01 = low-voltage differential; 2'b10 and 2'b11 are undefined. `mode_o` = 0 means single-ended and 1 means low-voltage differential. After the power-up window, one defined code held for SETTLE_MS*TICKS_PER_MS counted cycles raises `drv_en_o` and `mode_valid_o` together, with `mode_o` showing that code. With a steady single-ended code, `drv_en_o` rises after exactly PWRUP_MS*TICKS_PER_MS + SETTLE_MS*TICKS_PER_MS + 2 rising edges, counted from the first edge that samples `logic_ready_i` high.
- R4: During the settling window, an undefined code or a code different from the candidate restarts the window. A different defined code also becomes the new candidate. `drv_en_o` stays 0 throughout.
- R5: While the drivers are enabled, a defined code different from `mode_o` that is sampled on consecutive edges changes `mode_o` on the (SWITCH_MS*TICKS_PER_MS + 2)-th such edge, and at no earlier edge.
- R6: An undefined code, or the code of the current mode, sampled while a switch is pending cancels the switch. `mode_o` is unchanged, and a later attempt must start a full window again.
- R7: While a switch is pending, `mode_valid_o` = 0, `drv_en_o` = 1 and `mode_o` keeps the old mode. `mode_valid_o` returns to 1 on the edge that commits or cancels the switch.
- R8: Once `drv_en_o` is 1 it stays 1 until reset. `mode_o` moves from the old mode to the new one in a single clock cycle.
- R9: A reset during operation restores the R1 state, and the full power-up and settling sequence of R2 and R3 must run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| logic_ready_i | input | 1 | Level: the device logic is able to operate |
| sense_code_i | input | 2 | Classified mode-sense code (00 SE, 01 LVD, 1x undefined) |
| mode_o | output | 1 | Active mode: 0 single-ended, 1 low-voltage differential |
| drv_en_o | output | 1 | Signal drivers may leave high impedance |
| mode_valid_o | output | 1 | Drivers enabled and no mode switch pending |

## Verification
Every output comes from a register, so each result is due on the first clock edge that sees the deciding input. The one exception is the window ends, which appear one edge after the final counted cycle, giving the "+2" in R3 and R5. The bench drives inputs just after the falling edge and compares all three outputs with a behavioural model at every falling edge, so each result is checked in the cycle it is due. Two latencies are measured directly as edge counts: start-up (R3, R9) and switch commit (R5). Fixed-point checks also confirm that interrupted windows have not yet finished at the time an uninterrupted window would have.

// File: rtl/xmq_pkg.sv
package xmq_pkg;

   typedef enum logic [1:0] {
      PH_POWERUP = 2'd0,
      PH_SETTLE  = 2'd1,
      PH_ACTIVE  = 2'd2
   } phase_t;

   localparam logic MODE_SE  = 1'b0;
   localparam logic MODE_LVD = 1'b1;

   localparam logic [1:0] CODE_SE  = 2'b00;
   localparam logic [1:0] CODE_LVD = 2'b01;

   function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/xmq_sense_class.sv
module xmq_sense_class
   import xmq_pkg::*;
(
   input  logic [1:0] code_i,
   output logic       defined_o,
   output logic       mode_o
);

   always_comb begin
      unique case (code_i)
         CODE_SE:  begin defined_o = 1'b1; mode_o = MODE_SE;  end
         CODE_LVD: begin defined_o = 1'b1; mode_o = MODE_LVD; end
         default:  begin defined_o = 1'b0; mode_o = MODE_SE;  end
      endcase
   end

endmodule

// File: rtl/xmq_ms_prescaler.sv
module xmq_ms_prescaler #(
   parameter int unsigned TICKS_PER_MS = 200000
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clr_i,
   output logic tick_o
);

   localparam int unsigned PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;

   generate
      if (TICKS_PER_MS < 1) begin : g_bad_ticks
         $error("xmq_ms_prescaler: TICKS_PER_MS must be at least 1");
      end

      if (TICKS_PER_MS == 1) begin : g_direct
         assign tick_o = ~clr_i;
      end else begin : g_divide
         localparam logic [PRE_W-1:0] LAST = PRE_W'(TICKS_PER_MS - 1);
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk_i) begin
            if (rst_i || clr_i) begin
               pre_q <= '0;
            end else if (pre_q == LAST) begin
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end

         assign tick_o = ~clr_i && (pre_q == LAST);

         // R2
         tick_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            tick_o |=> !tick_o)
            else $error("millisecond tick repeated on consecutive cycles");
      end
   endgenerate

endmodule

// File: rtl/xmq_ms_timer.sv
module xmq_ms_timer #(
   parameter int unsigned TICKS_PER_MS = 200000,
   parameter int unsigned MS_W         = 8
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            clr_i,
   input  logic [MS_W-1:0] limit_i,
   output logic            done_o
);

   logic            tick;
   logic [MS_W-1:0] ms_q;

   generate
      if (MS_W < 1) begin : g_bad_width
         $error("xmq_ms_timer: MS_W must be at least 1");
      end
   endgenerate

   xmq_ms_prescaler #(
      .TICKS_PER_MS(TICKS_PER_MS)
   ) i_prescaler (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .clr_i (clr_i),
      .tick_o(tick)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
         ms_q <= '0;
      end else if (tick && (ms_q < limit_i)) begin
         ms_q <= ms_q + 1'b1;
      end
   end

   assign done_o = (ms_q >= limit_i);

   // R2
   done_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && !clr_i) |=> done_o)
      else $error("window done dropped without a clear");

endmodule

// File: rtl/xcvr_mode_qual.sv
module xcvr_mode_qual
   import xmq_pkg::*;
#(
   parameter int unsigned TICKS_PER_MS = 200000,
   parameter int unsigned PWRUP_MS     = 100,
   parameter int unsigned SETTLE_MS    = 100,
   parameter int unsigned SWITCH_MS    = 100
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       logic_ready_i,
   input  logic [1:0] sense_code_i,
   output logic       mode_o,
   output logic       drv_en_o,
   output logic       mode_valid_o
);

   localparam int unsigned MAX_MS = max3(PWRUP_MS, SETTLE_MS, SWITCH_MS);
   localparam int unsigned MS_W   = $clog2(MAX_MS + 1);

   generate
      if (TICKS_PER_MS < 1 || PWRUP_MS < 1 || SETTLE_MS < 1 || SWITCH_MS < 1) begin : g_bad_param
         $error("xcvr_mode_qual: tick rate and all windows must be at least 1");
      end
   endgenerate

   phase_t          phase_q, phase_d;
   logic            mode_q, mode_d;
   logic            cand_q, cand_d;
   logic            pend_q, pend_d;
   logic            sns_def, sns_mode;
   logic            win_clr, win_done;
   logic [MS_W-1:0] win_limit;

   xmq_sense_class i_sense (
      .code_i   (sense_code_i),
      .defined_o(sns_def),
      .mode_o   (sns_mode)
   );

   xmq_ms_timer #(
      .TICKS_PER_MS(TICKS_PER_MS),
      .MS_W        (MS_W)
   ) i_window (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .clr_i  (win_clr),
      .limit_i(win_limit),
      .done_o (win_done)
   );

   always_comb begin
      unique case (phase_q)
         PH_POWERUP: win_limit = MS_W'(PWRUP_MS);
         PH_SETTLE:  win_limit = MS_W'(SETTLE_MS);
         default:    win_limit = MS_W'(SWITCH_MS);
      endcase
   end

   always_comb begin
      phase_d = phase_q;
      mode_d  = mode_q;
      cand_d  = cand_q;
      pend_d  = pend_q;
      win_clr = 1'b0;
      unique case (phase_q)
         PH_POWERUP: begin
            if (win_done) begin
               phase_d = PH_SETTLE;
               win_clr = 1'b1;
            end else if (!logic_ready_i) begin
               win_clr = 1'b1;
            end
         end
         PH_SETTLE: begin
            if (win_done) begin
               phase_d = PH_ACTIVE;
               mode_d  = cand_q;
               win_clr = 1'b1;
            end else if (!sns_def || (sns_mode != cand_q)) begin
               win_clr = 1'b1;
               if (sns_def) begin
                  cand_d = sns_mode;
               end
            end
         end
         PH_ACTIVE: begin
            if (pend_q && win_done) begin
               mode_d  = ~mode_q;
               pend_d  = 1'b0;
               win_clr = 1'b1;
            end else if (sns_def && (sns_mode != mode_q)) begin
               if (!pend_q) begin
                  pend_d  = 1'b1;
                  win_clr = 1'b1;
               end
            end else begin
               pend_d  = 1'b0;
               win_clr = 1'b1;
            end
         end
         default: begin
            phase_d = PH_POWERUP;
            win_clr = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q <= PH_POWERUP;
         mode_q  <= MODE_SE;
         cand_q  <= MODE_SE;
         pend_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         mode_q  <= mode_d;
         cand_q  <= cand_d;
         pend_q  <= pend_d;
      end
   end

   assign mode_o       = mode_q;
   assign drv_en_o     = (phase_q == PH_ACTIVE);
   assign mode_valid_o = (phase_q == PH_ACTIVE) && !pend_q;

   // R8
   drv_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      drv_en_o |=> drv_en_o)
      else $error("driver enable dropped without reset");

   // R3
   drv_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(drv_en_o) |-> $past(win_done))
      else $error("drivers enabled before the settling window ended");

   // R5
   mode_commit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(mode_q) |-> $past(win_done))
      else $error("mode changed without a completed window");

   // R6
   undef_cancel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (drv_en_o && !sns_def) |=> !pend_q)
      else $error("undefined sense did not cancel a pending switch");

   // R7
   pend_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(pend_q) |-> ($past(sns_def) && ($past(sns_mode) != $past(mode_q))))
      else $error("switch became pending without a differing defined sense");

endmodule

// File: tb/test_xcvr_mode_qual.sv
`timescale 1ns/1ps
module test_xcvr_mode_qual;

   localparam int T  = 5;
   localparam int PW = 10;
   localparam int ST = 12;
   localparam int SW = 8;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ready = 1'b0;
   logic [1:0] sense = 2'b00;
   logic       mode, drv_en, valid;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   // behavioural reference state
   int m_ph   = 0;
   int m_cnt  = 0;
   int m_mode = 0;
   int m_cand = 0;
   int m_pend = 0;

   bit watch_active = 1'b0;
   bit seen_drop    = 1'b0;

   always #2.5 clk = ~clk;

   xcvr_mode_qual #(
      .TICKS_PER_MS(T),
      .PWRUP_MS    (PW),
      .SETTLE_MS   (ST),
      .SWITCH_MS   (SW)
   ) i_xcvr_mode_qual (
      .clk_i        (clk),
      .rst_i        (rst),
      .logic_ready_i(ready),
      .sense_code_i (sense),
      .mode_o       (mode),
      .drv_en_o     (drv_en),
      .mode_valid_o (valid)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   // Reference model: sees the same sampled inputs at each rising edge
   always @(posedge clk) begin
      bit def;
      int sm;
      def = (sense[1] == 1'b0);
      sm  = sense[0];
      if (rst) begin
         m_ph = 0; m_cnt = 0; m_mode = 0; m_cand = 0; m_pend = 0;
      end else begin
         case (m_ph)
            0: begin
               if (m_cnt >= PW*T) begin m_ph = 1; m_cnt = 0; end
               else if (ready) m_cnt++;
               else m_cnt = 0;
            end
            1: begin
               if (m_cnt >= ST*T) begin m_ph = 2; m_mode = m_cand; m_cnt = 0; end
               else if (!def || sm != m_cand) begin
                  m_cnt = 0;
                  if (def) m_cand = sm;
               end else m_cnt++;
            end
            default: begin
               if (m_pend != 0 && m_cnt >= SW*T) begin
                  m_mode = 1 - m_mode; m_pend = 0; m_cnt = 0;
               end else if (def && sm != m_mode) begin
                  if (m_pend == 0) begin m_pend = 1; m_cnt = 0; end
                  else m_cnt++;
               end else begin
                  m_pend = 0; m_cnt = 0;
               end
            end
         endcase
      end
   end

   // Per-cycle comparison with the model, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         chk("R2 drv_en vs model", drv_en, (m_ph == 2) ? 1 : 0);
         chk("R5 mode vs model", mode, m_mode);
         chk("R7 mode_valid vs model", valid, (m_ph == 2 && m_pend == 0) ? 1 : 0);
      end
      if (watch_active && !drv_en) seen_drop = 1'b1;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
         finish_run();
      end
   end

   initial begin
      int n;
      int prev;
      // R1: reset state
      step(4);
      chk("R1 drv_en in reset", drv_en, 0);
      chk("R1 mode_valid in reset", valid, 0);
      chk("R1 mode in reset", mode, 0);
      rst = 1'b0;
      step(1);
      chk("R1 drv_en after reset", drv_en, 0);
      chk("R1 mode after reset", mode, 0);

      // R2: not ready, then interrupted ready
      step(10);
      chk("R2 drv_en while not ready", drv_en, 0);
      ready = 1'b1;
      step(30);
      ready = 1'b0;
      step(1);
      ready = 1'b1;
      step(45);
      chk("R2 drv_en after restarted power-up", drv_en, 0);

      // R4: settle window with changes and an undefined code
      sense = 2'b01;
      step(10);
      step(30);
      sense = 2'b11;
      step(1);
      sense = 2'b01;
      step(50);
      chk("R4 drv_en after restarted settle", drv_en, 0);

      // R3: wait for commit to LVD
      n = 0;
      while (!drv_en && n < 200) begin step(1); n++; end
      chk("R3 drv_en after settle", drv_en, 1);
      chk("R3 mode committed to LVD", mode, 1);
      chk("R3 mode_valid after settle", valid, 1);
      watch_active = 1'b1;

      // R7: pending switch keeps old mode
      sense = 2'b00;
      step(20);
      chk("R7 mode_valid while pending", valid, 0);
      chk("R7 drv_en while pending", drv_en, 1);
      chk("R7 old mode while pending", mode, 1);

      // R6: return to current mode cancels
      sense = 2'b01;
      step(2);
      chk("R6 mode after cancel by current mode", mode, 1);
      chk("R6 mode_valid after cancel", valid, 1);

      // R6: undefined code cancels, window restarts
      sense = 2'b00;
      step(30);
      sense = 2'b10;
      step(1);
      sense = 2'b00;
      step(30);
      chk("R6 mode after undefined interruption", mode, 1);

      // R5: measured switch latency
      sense = 2'b01;
      step(3);
      sense = 2'b00;
      n = 0;
      prev = mode;
      while (mode == prev && n < 200) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      #1;
      chk("R5 switch latency in edges", n, SW*T + 2);
      chk("R8 single-cycle mode change to SE", mode, 0);
      chk("R7 mode_valid after commit", valid, 1);
      step(5);
      chk("R8 drv_en never dropped", seen_drop ? 1 : 0, 0);
      watch_active = 1'b0;

      // R9: reset during operation, full sequence again
      rst = 1'b1;
      ready = 1'b0;
      step(2);
      chk("R9 drv_en in mid-run reset", drv_en, 0);
      chk("R9 mode_valid in mid-run reset", valid, 0);
      chk("R9 mode in mid-run reset", mode, 0);
      rst = 1'b0;
      step(3);
      ready = 1'b1;
      n = 0;
      while (n < 500) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (drv_en) break;
      end
      #1;
      chk("R9 R3 start-up latency in edges", n, PW*T + ST*T + 2);
      chk("R9 mode after restart", mode, 0);
      step(5);
      finish_run();
   end

endmodule